// File: doc/BRIEF.md
# Byte-Aligned Container Delineator

This block finds where fixed-length transmission containers begin inside a received stream of 16-bit words. Each container opens with three header bytes and a check byte, followed by the payload. The check byte is a CRC-8 of the three header bytes. On every accepted word the block tests both byte lanes as possible check-byte positions. Headers may straddle two words, so containers can start on either byte lane.

The block is a three-state machine. From reset it is in **HUNT**. A correct check at any byte position moves it to **PRESYNC** (HUNT→PRESYNC), or straight to **SYNC** when the threshold is one (HUNT→SYNC). In PRESYNC it checks only at the spacing one container length apart. It moves to SYNC (PRESYNC→SYNC) once the number of consecutive correct checks reaches the configured confidence threshold. A single failure sends it back (PRESYNC→HUNT). In SYNC a run of seven failed checks returns it to HUNT (SYNC→HUNT), and any correct check clears that run (SYNC→SYNC).

While in sync, the block marks the word that holds each container's first byte and reports the byte lane of that first byte. It also reports the container offset of every word. It sits after a deserializer that produces words, and before a payload extractor.

Top module: `cell_delin`

## Requirements
- R1: After reset `sync_o`, `start_o`, `start_lane_o` and `word_ofs_o` are all 0 and the block is in HUNT.
- R2: The check byte equals the CRC-8 of the three header bytes, taken in stream order. The CRC uses generator x^8+x^2+x+1, MSB first, initial value 0, and the result is XORed with 0x55. Bits 15:8 of a word are the earlier byte in the stream. The container is laid out as header bytes at offsets 0 to 2, the check byte at offset 3, then the payload. Its length is `payload_len_i`+4 bytes, with `payload_len_i` from 2 to 64.
- R3: In HUNT both byte lanes of every accepted word are tested, including headers that span two words. A match on the high lane wins over a match on the low lane.
- R4: Sync needs `conf_thresh_i` consecutive correct checks spaced one container apart, counting the check found in HUNT (a threshold of 0 acts as 1). `sync_o` rises in the cycle after the word that carries the last of these check bytes.
- R5: In PRESYNC a failed check returns the block to HUNT and clears the count. The search then restarts at the next correct check.
- R6: In SYNC, seven consecutive failed checks return the block to HUNT, and `sync_o` falls in the cycle after the word holding the seventh failure. A correct check clears the run, and six failures keep sync.
- R7: While in sync, `start_o` is high with `valid_i` for a word that holds container offset 0. `start_lane_o` is 0 when that byte is bits 15:8 and 1 when it is bits 7:0. `start_lane_o` is 0 whenever `start_o` is 0.
- R8: While in sync, `word_ofs_o` is the container offset of bits 15:8 of the current word, and it is 0 when not in sync.
- R9: A cycle with `valid_i` low changes neither the state nor the offset, and drives `start_o` low.
- R10: With an odd container length, successive container starts alternate between byte lanes, and each start is reported on its own lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_i | input | 16 | Received word, bits 15:8 first in stream |
| valid_i | input | 1 | Word qualifier |
| payload_len_i | input | 7 | Payload length in bytes (2..64) |
| conf_thresh_i | input | 4 | Consecutive correct checks needed for sync |
| sync_o | output | 1 | Block is in SYNC |
| start_o | output | 1 | Current word holds a container's first byte |
| start_lane_o | output | 1 | Lane of that first byte (0 = bits 15:8) |
| word_ofs_o | output | 7 | Container offset of bits 15:8 of the current word |

## Verification
A wrong offset counter shows up as a `start_o` strobe on the wrong word or lane, or as a wrong `word_ofs_o`, in the first word after lock. If it goes undetected there, it causes a spurious loss of sync within seven containers. A wrong confidence or miss count moves the `sync_o` edge by at least one container length away from the word predicted from the threshold. A history register wired to the wrong lane stops lock entirely for boundaries on one of the two lanes. The sweep over every start phase for short containers catches this within a few containers.

// File: rtl/cell_delin_pkg.sv
package cell_delin_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int HDR_W  = 3 * BYTE_W;

    localparam logic [BYTE_W-1:0] HEC_POLY  = 8'h07;
    localparam logic [BYTE_W-1:0] HEC_COSET = 8'h55;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } dl_state_e;

    // CRC-8 over the three header bytes, first byte in the top bits
    function automatic logic [BYTE_W-1:0] hec_of(input logic [HDR_W-1:0] hdr);
        logic [BYTE_W-1:0] r;
        r = '0;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            if (r[BYTE_W-1] ^ hdr[i]) r = {r[BYTE_W-2:0], 1'b0} ^ HEC_POLY;
            else                      r = {r[BYTE_W-2:0], 1'b0};
        end
        return r ^ HEC_COSET;
    endfunction

endpackage

// File: rtl/cd_hec_check.sv
module cd_hec_check
    import cell_delin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              hi_ok_o,
    output logic              lo_ok_o
);

    logic [WORD_W-1:0] prev_q;
    logic [BYTE_W-1:0] older_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            older_q <= '0;
        end else if (valid_i) begin
            prev_q  <= word_i;
            older_q <= prev_q[BYTE_W-1:0];
        end
    end

    // high lane: header = older low, previous high, previous low
    // low lane: header = previous high, previous low, current high
    always_comb begin
        hi_ok_o = (hec_of({older_q, prev_q}) == word_i[WORD_W-1:BYTE_W]);
        lo_ok_o = (hec_of({prev_q, word_i[WORD_W-1:BYTE_W]}) == word_i[BYTE_W-1:0]);
    end

endmodule

// File: rtl/cd_pos_track.sv
module cd_pos_track #(
    parameter int OFS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [OFS_W-1:0] cont_len_i,
    input  logic             load_i,
    input  logic             load_lane_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             chk_hi_o,
    output logic             chk_lo_o,
    output logic             bnd_hi_o,
    output logic             bnd_lo_o
);

    localparam logic [OFS_W-1:0] CHK_OFS  = OFS_W'(3);
    localparam logic [OFS_W-1:0] PRE_OFS  = OFS_W'(2);
    localparam logic [OFS_W:0]   STEP     = (OFS_W+1)'(2);

    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] base;
    logic [OFS_W:0]   sum;
    logic [OFS_W:0]   len_x;
    logic [OFS_W-1:0] nxt;

    always_comb begin
        base  = load_i ? (load_lane_i ? PRE_OFS : CHK_OFS) : ofs_q;
        sum   = {1'b0, base} + STEP;
        len_x = {1'b0, cont_len_i};
        nxt   = (sum >= len_x) ? OFS_W'(sum - len_x) : OFS_W'(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ofs_q <= '0;
        else if (valid_i) ofs_q <= nxt;
    end

    always_comb begin
        ofs_o    = ofs_q;
        chk_hi_o = (ofs_q == CHK_OFS);
        chk_lo_o = (ofs_q == PRE_OFS);
        bnd_hi_o = (ofs_q == '0);
        bnd_lo_o = (ofs_q == cont_len_i - OFS_W'(1));
    end

    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ofs_q < cont_len_i) |=> (!$stable(cont_len_i) || ofs_q < cont_len_i)); // R8

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(ofs_q)); // R9

endmodule

// File: rtl/cd_sync_fsm.sv
module cd_sync_fsm
    import cell_delin_pkg::*;
#(
    parameter int THR_W      = 4,
    parameter int MISS_LIMIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             hi_ok_i,
    input  logic             lo_ok_i,
    input  logic             chk_hi_i,
    input  logic             chk_lo_i,
    input  logic [THR_W-1:0] thresh_i,
    output logic             load_o,
    output logic             load_lane_o,
    output logic             in_sync_o
);

    localparam int MISS_W = (MISS_LIMIT > 1) ? $clog2(MISS_LIMIT) : 1;
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    dl_state_e         state_q, state_n;
    logic [THR_W-1:0]  cnt_q, cnt_n;
    logic [MISS_W-1:0] miss_q, miss_n;
    logic [THR_W-1:0]  eff_thr;
    logic              chk, good, found;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            miss_q  <= miss_n;
        end
    end

    always_comb begin
        eff_thr     = (thresh_i == '0) ? THR_W'(1) : thresh_i;
        chk         = valid_i && (chk_hi_i || chk_lo_i);
        good        = chk_hi_i ? hi_ok_i : lo_ok_i;
        found       = valid_i && (hi_ok_i || lo_ok_i);
        state_n     = state_q;
        cnt_n       = cnt_q;
        miss_n      = miss_q;
        load_o      = 1'b0;
        load_lane_o = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (found) begin
                    load_o      = 1'b1;
                    load_lane_o = !hi_ok_i;
                    cnt_n       = THR_W'(1);
                    miss_n      = '0;
                    state_n     = (eff_thr == THR_W'(1)) ? ST_SYNC : ST_PRESYNC;
                end
            end
            ST_PRESYNC: begin
                if (chk) begin
                    if (!good) begin
                        state_n = ST_HUNT;
                        cnt_n   = '0;
                    end else if (({1'b0, cnt_q} + (THR_W+1)'(1)) >= {1'b0, eff_thr}) begin
                        state_n = ST_SYNC;
                        cnt_n   = '0;
                    end else begin
                        cnt_n   = cnt_q + THR_W'(1);
                    end
                end
            end
            ST_SYNC: begin
                if (chk) begin
                    if (good) begin
                        miss_n = '0;
                    end else if (miss_q == MISS_LAST) begin
                        miss_n  = '0;
                        state_n = ST_HUNT;
                    end else begin
                        miss_n = miss_q + MISS_W'(1);
                    end
                end
            end
            default: begin
                state_n = ST_HUNT;
                cnt_n   = '0;
                miss_n  = '0;
            end
        endcase
    end

    always_comb begin
        in_sync_o = (state_q == ST_SYNC);
    end

    AST_LOCK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_SYNC) |-> $past(valid_i && (hi_ok_i || lo_ok_i))); // R4

    AST_PRESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESYNC && chk && !good) |=> (state_q == ST_HUNT && cnt_q == '0)); // R5

    AST_SYNC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && chk && good) |=> (state_q == ST_SYNC && miss_q == '0)); // R6

    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q <= MISS_LAST); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(state_q) && $stable(cnt_q) && $stable(miss_q))); // R9

endmodule

// File: rtl/cell_delin.sv
module cell_delin
    import cell_delin_pkg::*;
#(
    parameter int MAX_PAYLOAD = 64,
    parameter int THR_W       = 4,
    parameter int MISS_LIMIT  = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [15:0]                           word_i,
    input  logic                                  valid_i,
    input  logic [$clog2(MAX_PAYLOAD+1)-1:0]      payload_len_i,
    input  logic [THR_W-1:0]                      conf_thresh_i,
    output logic                                  sync_o,
    output logic                                  start_o,
    output logic                                  start_lane_o,
    output logic [$clog2(MAX_PAYLOAD+5)-1:0]      word_ofs_o
);

    localparam int OFS_W = $clog2(MAX_PAYLOAD + 5);

    logic [OFS_W-1:0] cont_len;
    logic [OFS_W-1:0] ofs;
    logic             hi_ok, lo_ok;
    logic             chk_hi, chk_lo, bnd_hi, bnd_lo;
    logic             load, load_lane, in_sync;

    assign cont_len = OFS_W'(payload_len_i) + OFS_W'(4);

    cd_hec_check u_hec (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .word_i  (word_i),
        .hi_ok_o (hi_ok),
        .lo_ok_o (lo_ok)
    );

    cd_pos_track #(.OFS_W(OFS_W)) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .cont_len_i  (cont_len),
        .load_i      (load),
        .load_lane_i (load_lane),
        .ofs_o       (ofs),
        .chk_hi_o    (chk_hi),
        .chk_lo_o    (chk_lo),
        .bnd_hi_o    (bnd_hi),
        .bnd_lo_o    (bnd_lo)
    );

    cd_sync_fsm #(.THR_W(THR_W), .MISS_LIMIT(MISS_LIMIT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .hi_ok_i     (hi_ok),
        .lo_ok_i     (lo_ok),
        .chk_hi_i    (chk_hi),
        .chk_lo_i    (chk_lo),
        .thresh_i    (conf_thresh_i),
        .load_o      (load),
        .load_lane_o (load_lane),
        .in_sync_o   (in_sync)
    );

    always_comb begin
        sync_o       = in_sync;
        start_o      = in_sync && valid_i && (bnd_hi || bnd_lo);
        start_lane_o = in_sync && valid_i && !bnd_hi && bnd_lo;
        word_ofs_o   = in_sync ? ofs : '0;
    end

    AST_LOSS_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> $past(valid_i)); // R6

    AST_LANE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_lane_o |-> start_o); // R7

endmodule

// File: tb/cell_delin_test.sv
module cell_delin_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word_i = '0;
    logic        valid_i = 1'b0;
    logic [6:0]  payload_len_i = 7'd8;
    logic [3:0]  conf_thresh_i = 4'd8;
    logic        sync_o, start_o, start_lane_o;
    logic [6:0]  word_ofs_o;

    always #5 clk = ~clk;

    cell_delin uut (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .valid_i(valid_i),
        .payload_len_i(payload_len_i), .conf_thresh_i(conf_thresh_i),
        .sync_o(sync_o), .start_o(start_o), .start_lane_o(start_lane_o),
        .word_ofs_o(word_ofs_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    always @(posedge clk) cyc++;

    int L, sh, hb, ca, cb;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // bytewise CRC-8, generator 0x07, XOR 0x55 at the end (R2)
    function automatic logic [7:0] ref_hec(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        logic [7:0] r = 8'h00;
        logic [7:0] bytes [3];
        bytes[0] = a; bytes[1] = b; bytes[2] = c;
        for (int i = 0; i < 3; i++) begin
            r = r ^ bytes[i];
            for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r ^ 8'h55;
    endfunction

    function automatic logic [7:0] gen(int k, int len, int s, int h, int c0, int c1);
        int o, j;
        if (k < 0) return 8'h00;
        o = (k + s) % len;
        j = (k + s) / len;
        if (o < 3) return 8'(h + o);
        if (o == 3) return ref_hec(8'(h), 8'(h + 1), 8'(h + 2)) ^ ((j >= c0 && j < c1) ? 8'hFF : 8'h00);
        return 8'h00;
    endfunction

    // a header value is usable when no misaligned window matches
    function automatic bit clean(int h, int len);
        for (int s = 0; s < len; s++)
            for (int v = 0; v < 2; v++)
                for (int e = 0; e < 2 * len + 4; e++) begin
                    if (!(((e + s) % len == 3) && e >= 3)) begin
                        if (ref_hec(gen(e-3, len, s, h, 0, v*1000), gen(e-2, len, s, h, 0, v*1000),
                                    gen(e-1, len, s, h, 0, v*1000)) == gen(e, len, s, h, 0, v*1000))
                            return 1'b0;
                    end
                end
        return 1'b1;
    endfunction

    function automatic int wof(int j);
        return (j * L + 3 - sh) / 2;
    endfunction

    task automatic run(string rt, int pl, int s, int t, int mode, int pa, int m, bit gaps);
        int te, j0, jl, jlost, jre, jend, nw, n, c;
        bit lost, v, es, bh, bl;
        L = pl + 4; sh = s;
        hb = 16;
        for (int h = 16; h < 256; h++) if (clean(h, L)) begin hb = h; break; end
        te = (t == 0) ? 1 : t;
        j0 = (sh > 0) ? 1 : 0;
        ca = 0; cb = 0; lost = 0; jlost = 0; jre = 0;
        jl = j0 + te - 1;
        if (mode == 1) begin ca = j0 + pa; cb = ca + 1; jl = j0 + pa + te; end
        if (mode == 2) begin
            ca = jl + pa; cb = ca + m;
            if (m >= 7) begin lost = 1; jlost = ca + 6; jre = ca + 7 + te - 1; end
        end
        jend = (lost ? jre : (cb > jl ? cb : jl)) + 3;
        nw = wof(jend) + 2;
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1'b0; word_i = '0;
        payload_len_i = 7'(pl); conf_thresh_i = 4'(t);
        @(negedge clk); #1;
        chk("R1 sync after reset", sync_o, 0);
        chk("R1 start after reset", start_o, 0);
        chk("R1 lane after reset", start_lane_o, 0);
        chk("R1 offset after reset", word_ofs_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0; c = 0;
        while (n < nw) begin
            @(negedge clk);
            v = !(gaps && (c % 4 == 3));
            valid_i = v;
            word_i = {gen(2*n, L, sh, hb, ca, cb), gen(2*n+1, L, sh, hb, ca, cb)};
            #1;
            es = (n > 0) && ((n-1) >= wof(jl)) &&
                 !(lost && (n-1) >= wof(jlost) && (n-1) < wof(jre));
            chk(rt, sync_o, es);
            bh = ((2*n + sh) % L == 0);
            bl = ((2*n + 1 + sh) % L == 0);
            if (!v) chk("R9 no start on idle", start_o, 0);
            else if (L % 2 == 1) chk("R10 start odd length", start_o, es && (bh || bl));
            else chk("R7 start strobe", start_o, es && (bh || bl));
            chk("R7 start lane", start_lane_o, (v && es && !bh && bl) ? 1 : 0);
            chk("R8 word offset", word_ofs_o, es ? (2*n + sh) % L : 0);
            if (v) n++;
            c++;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_up();
    end

    initial begin
        run("R4 lock default threshold", 8, 0, 8, 0, 0, 0, 0);
        run("R2 lock odd length with gaps R9", 7, 5, 3, 0, 0, 0, 1);
        run("R6 loss after seven failures", 64, 37, 8, 2, 3, 7, 0);
        run("R6 six failures keep sync", 9, 2, 4, 2, 2, 6, 0);
        run("R5 presync failure restarts", 10, 7, 5, 1, 2, 0, 0);
        run("R5 first check corrupted", 6, 1, 3, 1, 0, 0, 1);
        run("R4 threshold zero acts as one", 2, 3, 0, 0, 0, 0, 0);
        // sweep of short containers over every start phase, both lanes (R3)
        for (int pl = 2; pl <= 12; pl++)
            for (int s = 0; s < pl + 4; s++)
                run("R3 sweep lock", pl, s, 2, 0, 0, 0, 0);
        finish_up();
    end

endmodule